// File: doc/BRIEF.md
# SPI Byte FIFO Status and Interrupt Unit

This block sits beside the shift engine of a serial peripheral interface and keeps the byte-level bookkeeping for both directions. The engine, in master or slave mode, signals each received byte with a strobe and asks for each byte to send with another strobe. The block stores received bytes in a small receive queue, and it holds bytes written by the host in a transmit queue. It counts completed bytes toward a programmed goal and raises sticky event flags. These flags are gathered onto a single interrupt line.

The host sees everything through one 16-bit read-only status word. A read strobe on that word clears the sticky flags. Two mask inputs keep queue overrun and underrun from reaching the interrupt line, and the flags still record those events. A mode input selects which direction's completion event is counted: transmit when it is high, receive when it is low. A level input serves two purposes. It sets the byte goal for the completion events, and it is the reference above which the receive queue reports an excess.

Top module: `spi_fifo_stat`

## Requirements
- R1: After reset the status word reads 0x0000, the interrupt output is low, and the transmit byte output is 0xFF.
- R2: The receive queue holds up to 4 bytes and returns them in arrival order at rx_data. Status bits 10:8 give the number of stored bytes, from 0 to 4. A pop while the queue is empty is ignored.
- R3: A received byte that arrives while the queue already holds 4 bytes sets the overrun flag at status bit 7. That byte is discarded, and the stored bytes and the count stay unchanged.
- R4: The transmit queue holds up to 4 bytes and shows its count at status bits 3:1. tx_byte presents the oldest byte, and each tx_start consumes one byte. A write while the queue is full is ignored.
- R5: A tx_start while the transmit queue is empty sets the underrun flag at status bit 4. In that case tx_byte is 0xFF and the count stays 0.
- R6: Status bit 11 is high exactly while the receive count is greater than rx_thresh. It is not sticky and follows a threshold change in the same cycle.
- R7: With irq_mode low, status bit 6 is set each time the number of accepted received bytes reaches the goal. A goal of 0 means every byte. With irq_mode high, received bytes never set bit 6.
- R8: With irq_mode high, status bit 5 is set each time the number of transmitted bytes reaches the goal given by rx_thresh. Underrun starts are not counted.
- R9: A status read clears bits 7 to 4 and bit 0 on the next cycle. Bits 15 to 12 always read as zero.
- R10: If a flag-setting event happens in the same cycle as a status read, the flag is set after that cycle.
- R11: irq is the OR of the receive-done flag, the transmit-done flag, the overrun flag unless ovf_mask is high, and the underrun flag unless unf_mask is high. Status bit 0 equals irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte_vld | input | 1 | Engine has received a byte |
| rx_byte | input | 8 | Received byte value |
| rx_pop | input | 1 | Host removes the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| tx_push | input | 1 | Host writes a byte to send |
| tx_wdata | input | 8 | Byte written to the transmit queue |
| tx_start | input | 1 | Engine takes the next byte to shift out |
| tx_byte | output | 8 | Byte handed to the engine (0xFF when empty) |
| irq_mode | input | 1 | 1: count transmitted bytes, 0: count received bytes |
| ovf_mask | input | 1 | Keeps overrun off the interrupt line |
| unf_mask | input | 1 | Keeps underrun off the interrupt line |
| rx_thresh | input | 3 | Byte goal (0 to 4) and excess reference |
| stat_rd | input | 1 | Status word read strobe (clears sticky flags) |
| stat_data | output | 16 | Status word |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong queue pointer or level shows up as a wrong count field in the cycle after the bad strobe. It also shows as out-of-order bytes at rx_data or tx_byte when the queues are drained later. A goal counter that is off by one moves the done flag one byte early or late, so the bench checks the flag after every byte of a run. A flag cleared by mistake or kept by mistake shows on bit 0 and on irq one cycle after the read strobe, and the bench checks it there, including the cycle where a read and an event coincide.

// File: rtl/spi_fs_pkg.sv
package spi_fs_pkg;
  localparam int FIFO_DEPTH = 4;
  localparam int BYTE_W     = 8;
  localparam int STAT_W     = 16;
  localparam int LVL_W      = 3;
  localparam int GOAL_W     = 3;

  // sticky flag slots inside the flag vector (MSB first maps to status 7..4)
  localparam int FL_OVF = 3;
  localparam int FL_RXD = 2;
  localparam int FL_TXD = 1;
  localparam int FL_UNF = 0;
  localparam int FL_N   = 4;
endpackage

// File: rtl/spi_fs_fifo.sv
module spi_fs_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DW-1:0]                din,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (lvl_q == CW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rd_q];
  assign level   = lvl_q;

  always_comb begin
    rd_d  = do_pop  ? bump(rd_q) : rd_q;
    wr_d  = do_push ? bump(wr_q) : wr_q;
    lvl_d = lvl_q;
    case ({do_push, do_pop})
      2'b10:   lvl_d = lvl_q + 1'b1;
      2'b01:   lvl_d = lvl_q - 1'b1;
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end
endmodule

// File: rtl/spi_fs_tally.sv
module spi_fs_tally #(
  parameter int DEPTH  = 4,
  parameter int GOAL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [GOAL_W-1:0] goal,
  output logic              hit
);
  localparam int TW = GOAL_W + 1;

  logic [GOAL_W-1:0] cnt_q, cnt_d;
  logic [TW-1:0]     goal_eff;

  always_comb begin
    if (goal == '0)                goal_eff = TW'(1);
    else if (TW'(goal) > TW'(DEPTH)) goal_eff = TW'(DEPTH);
    else                           goal_eff = TW'(goal);
  end

  assign hit = step && ((TW'(cnt_q) + TW'(1)) >= goal_eff);

  always_comb begin
    cnt_d = cnt_q;
    if (hit)       cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_fs_flags.sv
module spi_fs_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] fl_q, fl_d;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      fl_d[i] = set[i] | (fl_q[i] & ~clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= '0;
    else        fl_q <= fl_d;
  end

  assign flags = fl_q;
  assign irq   = |(fl_q & ~mask);
endmodule

// File: rtl/spi_fifo_stat.sv
module spi_fifo_stat
  import spi_fs_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH,
  parameter int DW    = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_byte_vld,
  input  logic [DW-1:0]     rx_byte,
  input  logic              rx_pop,
  output logic [DW-1:0]     rx_data,
  input  logic              tx_push,
  input  logic [DW-1:0]     tx_wdata,
  input  logic              tx_start,
  output logic [DW-1:0]     tx_byte,
  input  logic              irq_mode,
  input  logic              ovf_mask,
  input  logic              unf_mask,
  input  logic [GOAL_W-1:0] rx_thresh,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_data,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int XW = (CW > GOAL_W) ? CW : GOAL_W;

  logic [DW-1:0]  tx_head;
  logic [CW-1:0]  rx_lvl, tx_lvl;
  logic           rx_full, rx_empty, tx_full, tx_empty;
  logic           rx_accept, tx_take, ovf_evt, unf_evt;
  logic           rx_hit, tx_hit, excess;
  logic [FL_N-1:0] fl_set, fl_mask, flags;

  spi_fs_fifo #(.DEPTH(DEPTH), .DW(DW)) rx_q_i (
    .clk(clk), .rst_n(rst_n), .push(rx_byte_vld), .pop(rx_pop), .din(rx_byte),
    .head(rx_data), .level(rx_lvl), .full(rx_full), .empty(rx_empty)
  );

  spi_fs_fifo #(.DEPTH(DEPTH), .DW(DW)) tx_q_i (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_start), .din(tx_wdata),
    .head(tx_head), .level(tx_lvl), .full(tx_full), .empty(tx_empty)
  );

  assign rx_accept = rx_byte_vld & ~rx_full;
  assign ovf_evt   = rx_byte_vld &  rx_full;
  assign tx_take   = tx_start & ~tx_empty;
  assign unf_evt   = tx_start &  tx_empty;
  assign tx_byte   = tx_empty ? {DW{1'b1}} : tx_head;

  spi_fs_tally #(.DEPTH(DEPTH), .GOAL_W(GOAL_W)) rx_tally_i (
    .clk(clk), .rst_n(rst_n), .step(rx_accept & ~irq_mode), .goal(rx_thresh), .hit(rx_hit)
  );

  spi_fs_tally #(.DEPTH(DEPTH), .GOAL_W(GOAL_W)) tx_tally_i (
    .clk(clk), .rst_n(rst_n), .step(tx_take & irq_mode), .goal(rx_thresh), .hit(tx_hit)
  );

  always_comb begin
    fl_set          = '0;
    fl_set[FL_OVF]  = ovf_evt;
    fl_set[FL_RXD]  = rx_hit;
    fl_set[FL_TXD]  = tx_hit;
    fl_set[FL_UNF]  = unf_evt;
    fl_mask         = '0;
    fl_mask[FL_OVF] = ovf_mask;
    fl_mask[FL_UNF] = unf_mask;
  end

  spi_fs_flags #(.N(FL_N)) flags_i (
    .clk(clk), .rst_n(rst_n), .set(fl_set), .clr(stat_rd), .mask(fl_mask),
    .flags(flags), .irq(irq)
  );

  assign excess = XW'(rx_lvl) > XW'(rx_thresh);

  assign stat_data = {4'b0000, excess, LVL_W'(rx_lvl), flags, LVL_W'(tx_lvl), irq};

  logic unused_ok;
  assign unused_ok = tx_full ^ rx_empty;
endmodule

// File: rtl/spi_fs_chk.sv
module spi_fs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_byte_vld,
  input logic        rx_pop,
  input logic        tx_push,
  input logic        tx_start,
  input logic [7:0]  tx_byte,
  input logic        stat_rd,
  input logic [15:0] stat_data,
  input logic        irq
);
  // R2: receive count never exceeds the queue depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stat_data[10:8] <= 3'd4);

  // R3: arrival on a full queue sets overrun and keeps the count
  a_r3_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_byte_vld && !rx_pop && stat_data[10:8] == 3'd4) |=> (stat_data[7] && stat_data[10:8] == 3'd4));

  // R3: overrun is sticky until a read
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_data[7] && !stat_rd) |=> stat_data[7]);

  // R5: start on an empty transmit queue gives all ones and sets underrun
  a_r5_fill_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && stat_data[3:1] == 3'd0) |-> (tx_byte == 8'hFF));
  a_r5_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && stat_data[3:1] == 3'd0) |=> stat_data[4]);

  // R6: excess cannot be reported with an empty receive queue
  a_r6_excess_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    stat_data[11] |-> (stat_data[10:8] != 3'd0));

  // R9: a quiet read leaves no sticky flag and no interrupt
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rx_byte_vld && !tx_start) |=> (stat_data[7:4] == 4'd0 && !irq));

  // R10: event coinciding with a read survives the read
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && tx_start && stat_data[3:1] == 3'd0 && !tx_push) |=> stat_data[4]);

  // R11: no flag means no interrupt
  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_data[7:4] == 4'd0) |-> !irq);
endmodule

bind spi_fifo_stat spi_fs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_pop(rx_pop),
  .tx_push(tx_push), .tx_start(tx_start), .tx_byte(tx_byte), .stat_rd(stat_rd),
  .stat_data(stat_data), .irq(irq)
);

// File: tb/spi_fifo_stat_tb.sv
module spi_fifo_stat_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int NVEC       = 14;

  logic        clk, rst_n;
  logic        rx_byte_vld, rx_pop, tx_push, tx_start, irq_mode, ovf_mask, unf_mask, stat_rd;
  logic [7:0]  rx_byte, tx_wdata, rx_data, tx_byte;
  logic [2:0]  rx_thresh;
  logic [15:0] stat_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  spi_fifo_stat dut_i (
    .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
    .rx_pop(rx_pop), .rx_data(rx_data), .tx_push(tx_push), .tx_wdata(tx_wdata),
    .tx_start(tx_start), .tx_byte(tx_byte), .irq_mode(irq_mode), .ovf_mask(ovf_mask),
    .unf_mask(unf_mask), .rx_thresh(rx_thresh), .stat_rd(stat_rd),
    .stat_data(stat_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {rx_vld, rx_byte, rx_pop, tx_push, tx_wdata, tx_start, stat_rd, expected status}
  // mode 0, threshold 2, no masks
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0100}, // R2 one byte
    {1'b1, 8'h22, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0241}, // R7 goal reached
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 16'h0200}, // R9 read clears
    {1'b1, 8'h33, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0B00}, // R6 excess
    {1'b1, 8'h44, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0C41}, // R7 second goal
    {1'b1, 8'h55, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0CC1}, // R3 overrun
    {1'b1, 8'h66, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 16'h0C81}, // R10 set wins
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 16'h0C00}, // R9
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0B00}, // R2 pop
    {1'b0, 8'h00, 1'b0, 1'b1, 8'hAA, 1'b0, 1'b0, 16'h0B02}, // R4 push
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0B00}, // R8 no done in mode 0
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0B11}, // R5 underrun
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 16'h0B00}, // R9
    {1'b1, 8'h77, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0B00}  // R2 pop and push
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rx_byte_vld = 0; rx_pop = 0; tx_push = 0; tx_start = 0; stat_rd = 0;
    rx_byte = '0; tx_wdata = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0; irq_mode = 0; ovf_mask = 0; unf_mask = 0; rx_thresh = 3'd2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(stat_data, 16'h0000, "R1 status after reset");
    chk({15'd0, irq}, 16'd0, "R1 irq after reset");
    chk({8'd0, tx_byte}, 16'h00FF, "R1 tx byte after reset");

    for (int i = 0; i < NVEC; i++) begin
      {rx_byte_vld, rx_byte, rx_pop, tx_push, tx_wdata, tx_start, stat_rd} = VEC[i][36:16];
      tick();
      chk(stat_data, VEC[i][15:0], $sformatf("R2/R3/R7/R9 vector %0d", i));
      chk({15'd0, irq}, {15'd0, VEC[i][0]}, $sformatf("R11 irq vector %0d", i));
    end

    // R2: drain order 33 44 77, overrun bytes absent (R3)
    chk({8'd0, rx_data}, 16'h0033, "R2 head 1");
    rx_pop = 1; tick();
    chk({8'd0, rx_data}, 16'h0044, "R3 head 2 no lost order");
    rx_pop = 1; tick();
    chk({8'd0, rx_data}, 16'h0077, "R2 head 3");
    rx_pop = 1; tick();
    chk({13'd0, stat_data[10:8]}, 16'd0, "R2 empty");
    rx_pop = 1; tick();
    chk({13'd0, stat_data[10:8]}, 16'd0, "R2 pop on empty ignored");

    // R4/R8: transmit mode, goal 3
    irq_mode = 1; rx_thresh = 3'd3;
    for (int i = 0; i < 5; i++) begin
      tx_push = 1; tx_wdata = 8'hA1 + 8'(i); tick();
    end
    chk({13'd0, stat_data[3:1]}, 16'd4, "R4 full count, fifth write ignored");
    for (int i = 0; i < 3; i++) begin
      chk({8'd0, tx_byte}, 16'(8'hA1 + 8'(i)), "R4 transmit order");
      chk({15'd0, stat_data[5]}, 16'd0, "R8 done not early");
      tx_start = 1; tick();
    end
    chk({15'd0, stat_data[5]}, 16'd1, "R8 done after goal");
    chk({15'd0, irq}, 16'd1, "R11 irq on transmit done");
    stat_rd = 1; tick();
    chk(stat_data, 16'h0002, "R9 clear after read");
    chk({8'd0, tx_byte}, 16'h00A4, "R4 last byte, fifth not stored");
    tx_start = 1; tick();
    chk({8'd0, tx_byte}, 16'h00FF, "R5 fill byte when empty");
    chk({13'd0, stat_data[3:1]}, 16'd0, "R4 drained");

    // R7: receive bytes in transmit mode never set receive done
    for (int i = 0; i < 3; i++) begin
      rx_byte_vld = 1; rx_byte = 8'hC0 + 8'(i); tick();
    end
    chk({15'd0, stat_data[6]}, 16'd0, "R7 no receive done in mode 1");
    chk({15'd0, stat_data[11]}, 16'd0, "R6 count equal to threshold");
    rx_thresh = 3'd2; #1;
    chk({15'd0, stat_data[11]}, 16'd1, "R6 follows threshold change");

    // R11: masks
    ovf_mask = 1; unf_mask = 1;
    tx_start = 1; tick();
    chk({15'd0, stat_data[4]}, 16'd1, "R5 underrun recorded while masked");
    chk({15'd0, irq}, 16'd0, "R11 masked underrun");
    chk({15'd0, stat_data[0]}, 16'd0, "R11 summary bit masked");
    unf_mask = 0; #1;
    chk({15'd0, irq}, 16'd1, "R11 unmasked underrun");
    stat_rd = 1; tick();
    chk({15'd0, irq}, 16'd0, "R9 irq cleared by read");

    // R7: goal 0 means every byte
    irq_mode = 0; rx_thresh = 3'd0;
    rx_pop = 1; tick();
    rx_byte_vld = 1; rx_byte = 8'hD0; tick();
    chk({15'd0, stat_data[6]}, 16'd1, "R7 goal zero first byte");
    stat_rd = 1; tick();
    rx_byte_vld = 1; rx_byte = 8'hD1; tick();
    chk({15'd0, stat_data[6]}, 16'd1, "R7 goal zero next byte");
    chk({12'd0, stat_data[15:12]}, 16'd0, "R9 reserved bits zero");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule